// File: doc/BRIEF.md
# Machine Check Error Reporting Bank

This block is one error-logging bank for a single hardware unit, such as a cache or a bus interface. Each cycle it may receive an error report. A report carries a 16-bit error code, a flag that marks it correctable or uncorrectable, an address, a qualifier that says whether that address is a real translated address, and a qualifier that marks it as coming from a speculative load. A separate input reports a hard-failure response on an instruction fetch. The bank keeps the report in a 64-bit status word and an address register. It decides which report to keep, when to flag an overflow and when the stored address can be trusted. When a new uncorrectable error is logged and reporting is enabled, it raises a one-cycle machine-check request.

Software sees both registers at all times on the read outputs. It clears the bank by writing zero to the status word. After reset, or after the power-good input drops, the bank runs a fixed-length clearing sequence. It ignores every error report until that sequence ends.

Top module: `mc_err_bank`

## Requirements
- R1: While `rst_n` is low, and for exactly CLR_CYCLES (default 4) clock cycles after it goes high, `clr_busy` is 1, both registers read zero, and error reports are ignored.
- R2: The first accepted error sets status bit 63 (valid) and writes bit 61 (1 = uncorrectable) and bits 15:0 (error code). Every other bit reads 0.
- R3: Bit 62 (overflow) is set by any accepted error that arrives while bit 63 is already 1, whatever the kind of the stored error.
- R4: Once an uncorrectable error is stored, no later error changes any bit other than bit 62. This includes the error code.
- R5: A correctable error that arrives over a stored correctable error leaves the stored fields and the code unchanged and only sets bit 62.
- R6: An uncorrectable error that arrives over a stored correctable error replaces the whole word and sets bits 63, 62 and 61 together.
- R7: A report whose speculative qualifier is 1 changes neither register.
- R8: Bit 58 (address valid) and the address register are written only when the accepted report has `err_addr_ok` = 1. Otherwise bit 58 becomes 0 and the address register keeps its value.
- R9: A fetch hard-failure is logged as an uncorrectable error with code HF_CODE (default 16'h0C0F) and bit 58 = 0. It takes precedence over a report in the same cycle.
- R10: `mc_req` is high for exactly one cycle, at the moment the status word shows a newly logged uncorrectable error, and only if `mce_en` was 1 in the logging cycle.
- R11: A software write of zero clears the status word. A write of a nonzero value has no effect. If an error is accepted in the same cycle, the write is dropped and the error is applied to the current contents.
- R12: Asserting `rst_n` again during the clearing sequence restarts it at full length. `pwr_good` = 0 clears both registers and restarts the clearing sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Power good; 0 forces the cleared state |
| mce_en | input | 1 | Machine-check reporting enable |
| err_valid | input | 1 | An error report is present |
| err_code | input | 16 | Error code of the report |
| err_uc | input | 1 | 1 = uncorrectable, 0 = correctable |
| err_addr | input | ADDR_W | Address of the failing access |
| err_addr_ok | input | 1 | The address is a completed translation |
| err_spec | input | 1 | The report comes from a speculative load |
| fetch_hardfail | input | 1 | Hard-failure response on an instruction fetch |
| sw_wr | input | 1 | Software write strobe to the status word |
| sw_wdata | input | 64 | Software write data |
| status_o | output | 64 | Status word read value |
| addr_o | output | ADDR_W | Address register read value |
| clr_busy | output | 1 | Clearing sequence in progress |
| mc_req | output | 1 | One-cycle machine-check request |

## Verification
The hardest cases to reach are collisions between events that rarely meet in normal use. One is a zero write landing in the same cycle as an error over a stored uncorrectable entry. Another is a reset that returns partway through the clearing sequence. A third is a power-good drop while an entry is held. Directed stimulus builds each stored state first, then fires the colliding inputs on one clock edge. After that, a long stretch of random stimulus runs with short reset pulses and rare power drops. A behavioural reference model in the bench checks this stretch on every clock.

// File: rtl/mcb_pkg.sv
// Package: shared field positions and the internal error-event record
// for the machine check error reporting bank.
package mcb_pkg;
    localparam int STAT_W    = 64;
    localparam int CODE_W    = 16;
    localparam int BIT_VALID = 63;
    localparam int BIT_OVF   = 62;
    localparam int BIT_UC    = 61;
    localparam int BIT_AV    = 58;

    typedef struct packed {
        logic              fire;     // an event is accepted this cycle
        logic              uc;       // uncorrectable
        logic              addr_ok;  // address is usable
        logic [CODE_W-1:0] code;     // error code
    } mcb_event_t;
endpackage

// File: rtl/mcb_event_sel.sv
// Module: mcb_event_sel
// Turns the raw report inputs into one accepted event. It drops speculative
// reports and gives a fetch hard-failure precedence, logging it as an
// uncorrectable error with its own code and no address.
// Assumes: accept_en is low while the bank is clearing.
module mcb_event_sel
    import mcb_pkg::*;
#(
    parameter logic [CODE_W-1:0] HF_CODE = 16'h0C0F
) (
    input  logic              accept_en,
    input  logic              err_valid,
    input  logic [CODE_W-1:0] err_code,
    input  logic              err_uc,
    input  logic              err_addr_ok,
    input  logic              err_spec,
    input  logic              fetch_hardfail,
    output mcb_event_t        ev
);
    // Select the event source and qualify it.
    always_comb begin
        ev = '0;
        if (accept_en) begin
            if (fetch_hardfail) begin
                ev.fire    = 1'b1;
                ev.uc      = 1'b1;
                ev.addr_ok = 1'b0;
                ev.code    = HF_CODE;
            end else if (err_valid && !err_spec) begin
                ev.fire    = 1'b1;
                ev.uc      = err_uc;
                ev.addr_ok = err_addr_ok;
                ev.code    = err_code;
            end
        end
    end
endmodule

// File: rtl/mcb_clear_seq.sv
// Module: mcb_clear_seq
// Fixed-length clearing sequence. Reset or a power-good drop reloads the
// counter, so a repeated reset always restarts the full sequence.
// Assumes: CLR_CYCLES >= 1.
module mcb_clear_seq #(
    parameter int CLR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic busy
);
    localparam int CNT_W = $clog2(CLR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CLR_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Reload on reset or power loss, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            cnt <= CNT_LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Busy while any clearing cycles remain.
    always_comb busy = (cnt != '0);
endmodule

// File: rtl/mcb_status_upd.sv
// Module: mcb_status_upd
// Computes the next status word from the current word, the accepted event
// and a software clear. An empty bank takes any event. A stored correctable
// entry yields only to an uncorrectable one. Anything else just sets overflow.
// An accepted event wins over a software clear.
module mcb_status_upd
    import mcb_pkg::*;
(
    input  logic [STAT_W-1:0] cur,
    input  mcb_event_t        ev,
    input  logic              sw_clr,
    output logic [STAT_W-1:0] nxt,
    output logic              addr_we,
    output logic              log_uc
);
    logic replace;

    // Decide whether the event takes over the whole word.
    always_comb replace = ev.fire && (!cur[BIT_VALID] || (ev.uc && !cur[BIT_UC]));

    // Build the next word and the side strobes.
    always_comb begin
        nxt     = cur;
        addr_we = 1'b0;
        log_uc  = 1'b0;
        if (replace) begin
            nxt               = '0;
            nxt[BIT_VALID]    = 1'b1;
            nxt[BIT_OVF]      = cur[BIT_VALID];
            nxt[BIT_UC]       = ev.uc;
            nxt[BIT_AV]       = ev.addr_ok;
            nxt[CODE_W-1:0]   = ev.code;
            addr_we           = ev.addr_ok;
            log_uc            = ev.uc;
        end else if (ev.fire) begin
            nxt[BIT_OVF]      = 1'b1;
        end else if (sw_clr) begin
            nxt               = '0;
        end
    end
endmodule

// File: rtl/mc_err_bank.sv
// Module: mc_err_bank (top)
// One machine check error reporting bank: status word, address register and
// machine-check request. Software reads both registers directly and clears
// the status word with a zero write.
// Assumes: synchronous active-low reset; pwr_good low acts as a clear.
module mc_err_bank
    import mcb_pkg::*;
#(
    parameter int                ADDR_W     = 40,
    parameter int                CLR_CYCLES = 4,
    parameter logic [CODE_W-1:0] HF_CODE    = 16'h0C0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              mce_en,
    input  logic              err_valid,
    input  logic [CODE_W-1:0] err_code,
    input  logic              err_uc,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              err_addr_ok,
    input  logic              err_spec,
    input  logic              fetch_hardfail,
    input  logic              sw_wr,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] status_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              clr_busy,
    output logic              mc_req
);
    mcb_event_t        ev;
    logic [STAT_W-1:0] nxt_stat;
    logic              addr_we;
    logic              log_uc;
    logic              sw_clr;
    logic              busy;

    // Zero write from software requests a clear.
    always_comb sw_clr = sw_wr && (sw_wdata == '0);

    mcb_clear_seq #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .busy     (busy)
    );

    mcb_event_sel #(.HF_CODE(HF_CODE)) u_sel (
        .accept_en      (!busy),
        .err_valid      (err_valid),
        .err_code       (err_code),
        .err_uc         (err_uc),
        .err_addr_ok    (err_addr_ok),
        .err_spec       (err_spec),
        .fetch_hardfail (fetch_hardfail),
        .ev             (ev)
    );

    mcb_status_upd u_upd (
        .cur     (status_o),
        .ev      (ev),
        .sw_clr  (sw_clr && !busy),
        .nxt     (nxt_stat),
        .addr_we (addr_we),
        .log_uc  (log_uc)
    );

    // Bank registers: cleared on reset or power loss, otherwise updated.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            status_o <= '0;
            addr_o   <= '0;
            mc_req   <= 1'b0;
        end else begin
            status_o <= nxt_stat;
            if (addr_we) begin
                addr_o <= err_addr;
            end
            mc_req <= log_uc && mce_en;
        end
    end

    // Expose the clearing state.
    always_comb clr_busy = busy;
endmodule

// File: rtl/mcb_checker.sv
// Module: mcb_checker
// Property checks for mc_err_bank, attached by bind below.
module mcb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pwr_good,
    input logic        err_valid,
    input logic        err_spec,
    input logic        err_addr_ok,
    input logic        fetch_hardfail,
    input logic        sw_wr,
    input logic [63:0] sw_wdata,
    input logic [63:0] status_o,
    input logic        clr_busy,
    input logic        mc_req
);
    logic ev_in;
    logic sw_zero;
    always_comb ev_in   = (err_valid && !err_spec) || fetch_hardfail;
    always_comb sw_zero = sw_wr && (sw_wdata == 64'd0);

    // R1: nothing is logged while clearing
    p_busy_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |-> status_o == 64'd0);

    // R3: an accepted error over a valid entry sets overflow
    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !clr_busy && ev_in && status_o[63]) |=> status_o[62]);

    // R4: a stored uncorrectable entry changes only in the overflow bit
    p_uc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && status_o[63] && status_o[61] && !sw_zero)
        |=> {status_o[63], status_o[61:0]} == $past({status_o[63], status_o[61:0]}));

    // R7: speculative reports leave the status word untouched
    p_spec_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && err_valid && err_spec && !fetch_hardfail && !sw_zero) |=> $stable(status_o));

    // R8: a first error without a usable address leaves address-valid clear
    p_addr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !clr_busy && err_valid && !err_spec && !err_addr_ok
         && !fetch_hardfail && !status_o[63]) |=> (status_o[63] && !status_o[58]));

    // R10: a request always shows an uncorrectable entry and lasts one cycle
    p_req_uc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mc_req |-> (status_o[63] && status_o[61]));
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mc_req |=> !mc_req);
endmodule

bind mc_err_bank mcb_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_good       (pwr_good),
    .err_valid      (err_valid),
    .err_spec       (err_spec),
    .err_addr_ok    (err_addr_ok),
    .fetch_hardfail (fetch_hardfail),
    .sw_wr          (sw_wr),
    .sw_wdata       (sw_wdata),
    .status_o       (status_o),
    .clr_busy       (clr_busy),
    .mc_req         (mc_req)
);

// File: tb/mc_err_bank_test.sv
// Bench for mc_err_bank: directed checks plus a behavioural reference model
// compared on every clock.
module mc_err_bank_test;
    localparam int          ADDR_W = 40;
    localparam int          CLR    = 4;
    localparam logic [15:0] HF     = 16'h0C0F;

    logic              clk = 1'b0;
    logic              rst_n, pwr_good, mce_en, err_valid, err_uc, err_addr_ok;
    logic              err_spec, fetch_hardfail, sw_wr;
    logic [15:0]       err_code;
    logic [ADDR_W-1:0] err_addr;
    logic [63:0]       sw_wdata, status_o;
    logic [ADDR_W-1:0] addr_o;
    logic              clr_busy, mc_req;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string tag = "R1";

    // Reference model state
    logic [63:0]       m_stat = '0;
    logic [ADDR_W-1:0] m_addr = '0;
    int                m_cnt = CLR;
    bit                m_req = 0;
    bit                model_on = 0;

    mc_err_bank #(.ADDR_W(ADDR_W), .CLR_CYCLES(CLR), .HF_CODE(HF)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mce_en(mce_en),
        .err_valid(err_valid), .err_code(err_code), .err_uc(err_uc),
        .err_addr(err_addr), .err_addr_ok(err_addr_ok), .err_spec(err_spec),
        .fetch_hardfail(fetch_hardfail), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .status_o(status_o), .addr_o(addr_o), .clr_busy(clr_busy), .mc_req(mc_req)
    );

    always #4 clk = ~clk;  // 125 MHz

    function automatic logic [63:0] mk(bit v, bit o, bit u, bit a, logic [15:0] c);
        logic [63:0] w = '0;
        w[63] = v; w[62] = o; w[61] = u; w[58] = a; w[15:0] = c;
        return w;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge
    always @(posedge clk) begin
        bit fire, uc, aok;
        logic [15:0] code;
        if (!rst_n || !pwr_good) begin
            m_stat = '0; m_addr = '0; m_cnt = CLR; m_req = 0;
        end else if (m_cnt > 0) begin
            m_cnt--; m_req = 0;
        end else begin
            fire = 0; uc = 0; aok = 0; code = '0; m_req = 0;
            if (fetch_hardfail) begin
                fire = 1; uc = 1; code = HF;
            end else if (err_valid && !err_spec) begin
                fire = 1; uc = err_uc; aok = err_addr_ok; code = err_code;
            end
            if (fire) begin
                if (!m_stat[63] || (uc && !m_stat[61])) begin
                    m_stat = mk(1, m_stat[63], uc, aok, code);
                    if (aok) m_addr = err_addr;
                    m_req = uc && mce_en;
                end else begin
                    m_stat[62] = 1'b1;
                end
            end else if (sw_wr && sw_wdata == 64'd0) begin
                m_stat = '0;
            end
        end
    end

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (model_on && !done) begin
            chk({tag, " model status"}, status_o, m_stat);
            chk({tag, " model addr"}, 64'(addr_o), 64'(m_addr));
            chk({tag, " model busy"}, 64'(clr_busy), 64'(m_cnt > 0));
            chk({tag, " model req"}, 64'(mc_req), 64'(m_req));
        end
    end

    task automatic idle();
        err_valid = 0; err_uc = 0; err_addr_ok = 0; err_spec = 0;
        fetch_hardfail = 0; sw_wr = 0; sw_wdata = '0; err_code = '0; err_addr = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic report(bit uc, bit aok, bit spec, logic [15:0] code, logic [ADDR_W-1:0] a);
        err_valid = 1; err_uc = uc; err_addr_ok = aok; err_spec = spec;
        err_code = code; err_addr = a;
        tick();
    endtask

    task automatic sw_write(logic [63:0] d);
        sw_wr = 1; sw_wdata = d;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int busy_n;
        idle();
        rst_n = 0; pwr_good = 1; mce_en = 1;
        repeat (3) @(negedge clk);
        model_on = 1;
        // R1: reset state
        tag = "R1";
        chk("R1 reset status", status_o, '0);
        chk("R1 busy in reset", 64'(clr_busy), 64'd1);
        rst_n = 1;
        report(1, 1, 0, 16'h0077, 40'h1);   // ignored while clearing
        chk("R1 ignored while clearing", status_o, '0);
        busy_n = 1;
        while (clr_busy) begin tick(); busy_n++; end
        chk("R1 clear length", 64'(busy_n), 64'(CLR));

        tag = "R2";
        report(0, 1, 0, 16'h0011, 40'hA1);
        chk("R2 first log", status_o, mk(1, 0, 0, 1, 16'h0011));
        chk("R8 address stored", 64'(addr_o), 64'h00A1);
        tag = "R5";
        report(0, 1, 0, 16'h0022, 40'hB2);
        chk("R5 corr retention", status_o, mk(1, 1, 0, 1, 16'h0011));
        chk("R3 overflow", 64'(status_o[62]), 64'd1);
        chk("R5 addr kept", 64'(addr_o), 64'h00A1);
        tag = "R7";
        report(1, 1, 1, 16'h0099, 40'hC3);
        chk("R7 speculative ignored", status_o, mk(1, 1, 0, 1, 16'h0011));
        tag = "R6";
        report(1, 0, 0, 16'h0033, 40'hD4);
        chk("R6 uc overwrite", status_o, mk(1, 1, 1, 0, 16'h0033));
        chk("R8 addr not written", 64'(addr_o), 64'h00A1);
        chk("R10 request", 64'(mc_req), 64'd1);
        tag = "R4";
        report(0, 1, 0, 16'h0044, 40'hE5);
        chk("R10 one cycle", 64'(mc_req), 64'd0);
        report(1, 1, 0, 16'h0055, 40'hE6);
        chk("R4 uc retained", status_o, mk(1, 1, 1, 0, 16'h0033));
        tag = "R11";
        sw_write(64'h5);
        chk("R11 nonzero write ignored", status_o, mk(1, 1, 1, 0, 16'h0033));
        sw_write('0);
        chk("R11 zero write clears", status_o, '0);
        tag = "R10";
        mce_en = 0;
        report(1, 1, 0, 16'h0066, 40'hF7);
        chk("R10 no request when disabled", 64'(mc_req), 64'd0);
        chk("R3 no overflow on first", status_o, mk(1, 0, 1, 1, 16'h0066));
        mce_en = 1;
        tag = "R11";
        sw_wr = 1; sw_wdata = '0;
        report(0, 0, 0, 16'h0088, 40'h1);
        chk("R11 event beats clear", status_o, mk(1, 1, 1, 1, 16'h0066));
        sw_write('0);
        tag = "R9";
        fetch_hardfail = 1;
        report(0, 1, 0, 16'h0123, 40'h2);
        chk("R9 hard fail logged", status_o, mk(1, 0, 1, 0, HF));
        chk("R9 request", 64'(mc_req), 64'd1);
        tag = "R12";
        rst_n = 0; tick(); rst_n = 1;
        tick(); tick();
        rst_n = 0; tick(); rst_n = 1;
        busy_n = 0;
        while (clr_busy) begin tick(); busy_n++; end
        chk("R12 restart full clear", 64'(busy_n), 64'(CLR));
        report(0, 1, 0, 16'h0abc, 40'h3);
        pwr_good = 0; tick(); pwr_good = 1;
        chk("R12 power drop clears", status_o, '0);
        chk("R12 power drop restarts", 64'(clr_busy), 64'd1);
        repeat (CLR) tick();

        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            err_valid = $urandom_range(0, 2) != 0;
            err_uc = $urandom_range(0, 3) == 0;
            err_addr_ok = $urandom_range(0, 1) == 1;
            err_spec = $urandom_range(0, 4) == 0;
            fetch_hardfail = $urandom_range(0, 30) == 0;
            err_code = 16'($urandom);
            err_addr = {8'($urandom), 32'($urandom)};
            sw_wr = $urandom_range(0, 8) == 0;
            sw_wdata = ($urandom_range(0, 1) == 1) ? 64'd0 : 64'd3;
            mce_en = $urandom_range(0, 1) == 1;
            rst_n = $urandom_range(0, 150) != 0;
            pwr_good = $urandom_range(0, 300) != 0;
            @(negedge clk);
        end
        idle(); rst_n = 1; pwr_good = 1;
        tick();
        model_on = 0;
        finish_run();
    end
endmodule